// File: doc/BRIEF.md
# Safe System Clock Source Switcher

This block picks the system clock from five oscillator sources: a high-speed crystal, a 32.768 kHz crystal, a PLL output, a 10 kHz RC and a 22.1184 MHz RC. Software requests a source by writing a 3-bit select code. The write takes effect only while the register-protection unlock input is high. The switcher does not act on the request at once. It keeps the system clock on the source in use until both that source and the requested one report stable. It then stops the old clock while it is low, and opens the new clock on its own falling edge. The system clock therefore never carries a shortened pulse.

A control domain clocked by `ctl_clk` holds the request register and the handover sequencer. Each source has a gating cell in its own clock domain. Enables and acknowledges cross between the domains through two-flop synchronisers. On every reset the select code is reloaded from a boot configuration input, so the system starts on either the high-speed crystal or the 22.1184 MHz RC. A status bit stays high for as long as the source that actually drives the system clock differs from the requested one.

Top module: `sysclk_switch`

## Requirements
- R1: Select codes map to sources as follows: 3'b000 high-speed crystal (source index 0), 3'b001 32.768 kHz crystal (index 1), 3'b010 PLL (index 2), 3'b011 10 kHz RC (index 3), 3'b111 22.1184 MHz RC (index 4). Once a switch completes, `sys_clk` follows `src_clk[index]` of the selected source.
- R2: While `rst_n` is low, the request code loads 3'b111 when `cfg_boot_rc` is 1 and 3'b000 when it is 0. After reset, `cur_src` equals that code, `sw_fail` is 0, and `sys_clk` starts following that source.
- R3: After a new source is requested, `sys_clk` stays on the previous source for as long as the requested source's stable input is 0.
- R4: `sw_fail` is 1 whenever `cur_src` differs from the requested code. It is 1 from the `ctl_clk` cycle after an accepted write that names a different source, and it returns to 0 when the switch completes.
- R5: `stable_flags[i]` reports `src_stable[i]` after two `ctl_clk` rising edges, for each of the five sources.
- R6: A switch does not begin while the stable input of the source now in use is 0, even if the requested source is stable.
- R7: A write made with `wr_unlock` at 0 leaves the request unchanged, so `sw_fail` and `cur_src` do not move.
- R8: `sys_clk` carries no high or low pulse shorter than the narrowest half-period of the selected sources, and no two source gates are open at the same time.
- R9: An unlocked write of a reserved code (3'b100, 3'b101 or 3'b110) sets the request to the code of the source in use. Any pending switch that has not yet started is cancelled and `sw_fail` reads 0.
- R10: `cur_src` always holds the code of the source whose gate is, or was last, open for the system clock, and it is always one of the five valid codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control-domain clock for the request register and the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_boot_rc | input | 1 | Boot configuration: 1 boots on the 22.1184 MHz RC, 0 on the high-speed crystal |
| src_clk | input | 5 | Source clocks, indexed as in R1 |
| src_stable | input | 5 | Per-source stable indications, indexed as in R1 |
| sel_we | input | 1 | Write strobe for the select code |
| sel_wdata | input | 3 | Select code to write |
| wr_unlock | input | 1 | Register-protection unlock; a write counts only while this is high |
| sys_clk | output | 1 | Glitch-free system clock |
| cur_src | output | 3 | Code of the source driving the system clock |
| sw_fail | output | 1 | High while the driving source differs from the request |
| stable_flags | output | 5 | Synchronised per-source stable flags |

## Verification
The assertions assume that `sel_we`, `sel_wdata` and `wr_unlock` change only away from the rising edge of `ctl_clk`. They also assume that every source clock keeps toggling while its gate is asked to open or close. If a clock stood still, the handover would stall rather than break the break-before-make order. The stimulus drives all control inputs on falling edges of `ctl_clk` and keeps all five source clocks free-running at fixed, different periods. It lowers a stable input only to hold a switch off, never while a handover is in progress. The system clock is compared with the expected source at instants that fall between all clock edges.

// File: rtl/sysclk_switch_pkg.sv
package sysclk_switch_pkg;

    localparam int NSRC  = 5;
    localparam int SEL_W = 3;
    localparam int IDX_W = $clog2(NSRC);

    typedef enum logic [1:0] {
        PH_BOOT,
        PH_RUN,
        PH_STOP,
        PH_START
    } phase_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [IDX_W-1:0] act;
        logic [IDX_W-1:0] tgt;
        phase_e           ph;
        logic [NSRC-1:0]  en;
    } ctrl_st_t;

    function automatic logic code_valid(input logic [SEL_W-1:0] c);
        return (c == 3'b000) || (c == 3'b001) || (c == 3'b010) ||
               (c == 3'b011) || (c == 3'b111);
    endfunction

    function automatic logic [IDX_W-1:0] code_to_idx(input logic [SEL_W-1:0] c);
        logic [IDX_W-1:0] r;
        case (c)
            3'b000:  r = 3'd0;
            3'b001:  r = 3'd1;
            3'b010:  r = 3'd2;
            3'b011:  r = 3'd3;
            default: r = 3'd4;
        endcase
        return r;
    endfunction

    function automatic logic [SEL_W-1:0] idx_to_code(input logic [IDX_W-1:0] i);
        logic [SEL_W-1:0] r;
        case (i)
            3'd0:    r = 3'b000;
            3'd1:    r = 3'b001;
            3'd2:    r = 3'b010;
            3'd3:    r = 3'b011;
            default: r = 3'b111;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sysclk_sync.sv
module sysclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sysclk_gate_cell.sv
module sysclk_gate_cell #(
    parameter int STAGES = 2
) (
    input  logic src_clk,
    input  logic ctl_clk,
    input  logic rst_n,
    input  logic en,
    output logic clk_out,
    output logic ack
);
    logic en_s;
    logic gate_q;

    // Enable crosses into the source domain.
    sysclk_sync #(.STAGES(STAGES)) u_en_sync (
        .clk(src_clk), .rst_n(rst_n), .d(en), .q(en_s)
    );

    // Gate state changes only while the source clock is low.
    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= en_s;
    end

    assign clk_out = src_clk & gate_q;

    // Gate state is reported back to the control domain.
    sysclk_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk(ctl_clk), .rst_n(rst_n), .d(gate_q), .q(ack)
    );
endmodule

// File: rtl/sysclk_switch_ctrl.sv
module sysclk_switch_ctrl
    import sysclk_switch_pkg::*;
(
    input  logic             ctl_clk,
    input  logic             rst_n,
    input  logic             cfg_boot_rc,
    input  logic [NSRC-1:0]  stable_s,
    input  logic [NSRC-1:0]  ack_s,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             wr_unlock,
    output logic [NSRC-1:0]  gate_en,
    output logic [SEL_W-1:0] sel_req,
    output logic [SEL_W-1:0] cur_src,
    output logic             sw_fail
);
    ctrl_st_t st_d, st_q;
    logic [IDX_W-1:0] req_idx;

    always_comb begin
        st_d    = st_q;
        req_idx = code_to_idx(st_q.sel);

        if (sel_we && wr_unlock) begin
            st_d.sel = code_valid(sel_wdata) ? sel_wdata : idx_to_code(st_q.act);
        end

        case (st_q.ph)
            PH_BOOT: begin
                if (ack_s[st_q.act]) st_d.ph = PH_RUN;
            end
            PH_RUN: begin
                if ((req_idx != st_q.act) && stable_s[req_idx] && stable_s[st_q.act]) begin
                    st_d.tgt         = req_idx;
                    st_d.en[st_q.act] = 1'b0;
                    st_d.ph          = PH_STOP;
                end
            end
            PH_STOP: begin
                if (!ack_s[st_q.act]) begin
                    st_d.en[st_q.tgt] = 1'b1;
                    st_d.ph           = PH_START;
                end
            end
            default: begin
                if (ack_s[st_q.tgt]) begin
                    st_d.act = st_q.tgt;
                    st_d.ph  = PH_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge ctl_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel <= cfg_boot_rc ? 3'b111 : 3'b000;
            st_q.act <= cfg_boot_rc ? 3'd4 : 3'd0;
            st_q.tgt <= cfg_boot_rc ? 3'd4 : 3'd0;
            st_q.ph  <= PH_BOOT;
            st_q.en  <= cfg_boot_rc ? 5'b10000 : 5'b00001;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_en = st_q.en;
    assign sel_req = st_q.sel;
    assign cur_src = idx_to_code(st_q.act);
    assign sw_fail = (st_q.sel != cur_src);
endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
    import sysclk_switch_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             ctl_clk,
    input  logic             rst_n,
    input  logic             cfg_boot_rc,
    input  logic [NSRC-1:0]  src_clk,
    input  logic [NSRC-1:0]  src_stable,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             wr_unlock,
    output logic             sys_clk,
    output logic [SEL_W-1:0] cur_src,
    output logic             sw_fail,
    output logic [NSRC-1:0]  stable_flags
);
    logic [NSRC-1:0]  stable_s;
    logic [NSRC-1:0]  ack_s;
    logic [NSRC-1:0]  gate_en;
    logic [NSRC-1:0]  gated;
    logic [SEL_W-1:0] sel_req;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        sysclk_sync #(.STAGES(SYNC_STAGES)) u_stable_sync (
            .clk(ctl_clk), .rst_n(rst_n), .d(src_stable[i]), .q(stable_s[i])
        );
        sysclk_gate_cell #(.STAGES(SYNC_STAGES)) u_cell (
            .src_clk(src_clk[i]), .ctl_clk(ctl_clk), .rst_n(rst_n),
            .en(gate_en[i]), .clk_out(gated[i]), .ack(ack_s[i])
        );
    end

    sysclk_switch_ctrl u_ctrl (
        .ctl_clk(ctl_clk), .rst_n(rst_n), .cfg_boot_rc(cfg_boot_rc),
        .stable_s(stable_s), .ack_s(ack_s), .sel_we(sel_we),
        .sel_wdata(sel_wdata), .wr_unlock(wr_unlock), .gate_en(gate_en),
        .sel_req(sel_req), .cur_src(cur_src), .sw_fail(sw_fail)
    );

    assign sys_clk      = |gated;
    assign stable_flags = stable_s;
endmodule

// File: rtl/sysclk_switch_chk.sv
module sysclk_switch_chk
    import sysclk_switch_pkg::*;
(
    input logic             ctl_clk,
    input logic             rst_n,
    input logic             sel_we,
    input logic [SEL_W-1:0] sel_wdata,
    input logic             wr_unlock,
    input logic [SEL_W-1:0] sel_req,
    input logic [SEL_W-1:0] cur_src,
    input logic [NSRC-1:0]  ack_s
);
    // R7: locked writes leave the request alone
    a_r7_locked_write: assert property (@(posedge ctl_clk) disable iff (!rst_n)
        (sel_we && !wr_unlock) |=> $stable(sel_req));

    // R9: reserved code becomes the code of the source in use
    a_r9_reserved_current: assert property (@(posedge ctl_clk) disable iff (!rst_n)
        (sel_we && wr_unlock && (sel_wdata inside {3'b100, 3'b101, 3'b110}))
        |=> (sel_req == $past(cur_src)));

    // R10: the reported source is always a legal code
    a_r10_cur_valid: assert property (@(posedge ctl_clk) disable iff (!rst_n)
        cur_src inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b111});

    // R8: never two gates acknowledged at once
    a_r8_single_gate: assert property (@(posedge ctl_clk) disable iff (!rst_n)
        $countones(ack_s) <= 1);

    // R8: a new gate opens only after the old one is seen closed
    a_r8_break_before_make: assert property (@(posedge ctl_clk) disable iff (!rst_n)
        ((ack_s != $past(ack_s)) && (ack_s != '0)) |-> ($past(ack_s) == '0));
endmodule

bind sysclk_switch sysclk_switch_chk u_chk (
    .ctl_clk(ctl_clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .wr_unlock(wr_unlock), .sel_req(sel_req), .cur_src(cur_src), .ack_s(ack_s)
);

// File: tb/sysclk_switch_bench.sv
`timescale 1ns/1ps
module sysclk_switch_bench;
    logic       ctl_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_boot_rc = 1'b0;
    logic [4:0] src_clk = '0;
    logic [4:0] src_stable = 5'b11111;
    logic       sel_we = 1'b0;
    logic [2:0] sel_wdata = '0;
    logic       wr_unlock = 1'b0;
    logic       sys_clk;
    logic [2:0] cur_src;
    logic       sw_fail;
    logic [4:0] stable_flags;

    int n_chk = 0;
    int n_bad = 0;

    sysclk_switch u_sysclk_switch (
        .ctl_clk(ctl_clk), .rst_n(rst_n), .cfg_boot_rc(cfg_boot_rc),
        .src_clk(src_clk), .src_stable(src_stable), .sel_we(sel_we),
        .sel_wdata(sel_wdata), .wr_unlock(wr_unlock), .sys_clk(sys_clk),
        .cur_src(cur_src), .sw_fail(sw_fail), .stable_flags(stable_flags)
    );

    always #5 ctl_clk = ~ctl_clk;
    always #7  src_clk[0] = ~src_clk[0];
    always #15 src_clk[1] = ~src_clk[1];
    always #4  src_clk[2] = ~src_clk[2];
    always #23 src_clk[3] = ~src_clk[3];
    always #9  src_clk[4] = ~src_clk[4];

    // pulse-width monitor for R8
    bit    mon_on = 1'b0;
    bit    have_last = 1'b0;
    realtime last_t = 0.0;
    int    n_runt = 0;
    always @(sys_clk) begin
        if (rst_n && mon_on) begin
            if (have_last && (($realtime - last_t) < 3.9)) n_runt++;
            last_t = $realtime;
            have_last = 1'b1;
        end else begin
            have_last = 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge ctl_clk);
    endtask

    task automatic do_reset(input bit rc);
        @(negedge ctl_clk);
        cfg_boot_rc = rc;
        rst_n = 1'b0;
        cycles(4);
        rst_n = 1'b1;
        cycles(30);
    endtask

    task automatic write_sel(input logic [2:0] code, input bit unlock);
        @(negedge ctl_clk);
        sel_we = 1'b1;
        sel_wdata = code;
        wr_unlock = unlock;
        @(negedge ctl_clk);
        sel_we = 1'b0;
        wr_unlock = 1'b0;
    endtask

    task automatic settle();
        for (int i = 0; i < 300; i++) begin
            if (!sw_fail) break;
            @(negedge ctl_clk);
        end
    endtask

    // compare sys_clk with a source at instants between all edges
    task automatic check_follow(input int idx, input string tag);
        int miss = 0;
        #0.25;
        for (int i = 0; i < 60; i++) begin
            if (sys_clk !== src_clk[idx]) miss++;
            #1;
        end
        check(miss == 0, tag, miss, 0);
    endtask

    task automatic t_reset_xtal();
        do_reset(1'b0);
        check(cur_src == 3'b000, "R2 boot code xtal", cur_src, 0);
        check(sw_fail == 1'b0, "R2 no fail after reset", sw_fail, 0);
        check_follow(0, "R2 R1 follows xtal after boot");
    endtask

    task automatic t_switch_pll();
        write_sel(3'b010, 1'b1);
        check(sw_fail == 1'b1, "R4 fail right after write", sw_fail, 1);
        check(cur_src == 3'b000, "R3 still old source", cur_src, 0);
        settle();
        check(cur_src == 3'b010, "R10 cur is pll", cur_src, 2);
        check(sw_fail == 1'b0, "R4 fail cleared", sw_fail, 0);
        check_follow(2, "R1 follows pll");
    endtask

    task automatic t_wait_unstable();
        src_stable[3] = 1'b0;
        write_sel(3'b011, 1'b1);
        cycles(60);
        check(sw_fail == 1'b1, "R3 pending while target unstable", sw_fail, 1);
        check(cur_src == 3'b010, "R3 cur unchanged", cur_src, 2);
        check_follow(2, "R3 clock stays on pll");
        src_stable[3] = 1'b1;
        settle();
        check(cur_src == 3'b011, "R3 switch done to lirc", cur_src, 3);
        check_follow(3, "R1 follows lirc");
    endtask

    task automatic t_old_unstable();
        src_stable[3] = 1'b0;
        write_sel(3'b001, 1'b1);
        cycles(60);
        check(cur_src == 3'b011, "R6 held by unstable old source", cur_src, 3);
        check(sw_fail == 1'b1, "R6 fail while held", sw_fail, 1);
        src_stable[3] = 1'b1;
        settle();
        check(cur_src == 3'b001, "R6 switch done to lxt", cur_src, 1);
        check_follow(1, "R1 follows lxt");
    endtask

    task automatic t_locked();
        write_sel(3'b111, 1'b0);
        cycles(10);
        check(sw_fail == 1'b0, "R7 locked write no fail", sw_fail, 0);
        check(cur_src == 3'b001, "R7 locked write cur same", cur_src, 1);
        check_follow(1, "R7 clock unchanged");
    endtask

    task automatic t_reserved();
        src_stable[4] = 1'b0;
        write_sel(3'b111, 1'b1);
        cycles(10);
        check(sw_fail == 1'b1, "R9 pending before reserved write", sw_fail, 1);
        write_sel(3'b101, 1'b1);
        check(sw_fail == 1'b0, "R9 reserved cancels pending", sw_fail, 0);
        src_stable[4] = 1'b1;
        cycles(30);
        check(cur_src == 3'b001, "R9 cur stays lxt", cur_src, 1);
        write_sel(3'b110, 1'b1);
        cycles(5);
        check(sw_fail == 1'b0, "R9 reserved 110 no fail", sw_fail, 0);
        check_follow(1, "R9 clock unchanged");
    endtask

    task automatic t_stable_flags();
        @(negedge ctl_clk);
        src_stable = 5'b10110;
        cycles(1);
        check(stable_flags == 5'b11111, "R5 not yet after one edge", stable_flags, 31);
        cycles(1);
        check(stable_flags == 5'b10110, "R5 flags after two edges", stable_flags, 22);
        src_stable = 5'b11111;
        cycles(3);
        check(stable_flags == 5'b11111, "R5 flags restored", stable_flags, 31);
    endtask

    task automatic t_glitch();
        n_runt = 0;
        mon_on = 1'b1;
        write_sel(3'b111, 1'b1);
        settle();
        check_follow(4, "R1 follows hirc");
        write_sel(3'b010, 1'b1);
        settle();
        write_sel(3'b000, 1'b1);
        settle();
        check_follow(0, "R1 back on xtal");
        mon_on = 1'b0;
        check(n_runt == 0, "R8 no short pulses", n_runt, 0);
    endtask

    task automatic t_reset_rc();
        do_reset(1'b1);
        check(cur_src == 3'b111, "R2 boot code hirc", cur_src, 7);
        check(sw_fail == 1'b0, "R2 no fail after rc boot", sw_fail, 0);
        check_follow(4, "R2 follows hirc after boot");
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_xtal();
        t_switch_pll();
        t_wait_unstable();
        t_old_unstable();
        t_locked();
        t_reserved();
        t_stable_flags();
        t_glitch();
        t_reset_rc();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule